// File: doc/BRIEF.md
# Dual-Mode Converter Settings Port

This block takes the settings for an audio digital-to-analog converter over three general-purpose control lines and a mode pin. With the mode pin low, the lines form a serial port: one line clocks bits in, one line strobes a finished 8-bit word into the setting registers, and one carries the data. With the mode pin high, the same three lines become static levels that directly select de-emphasis, double-speed playback and soft mute.

All four inputs are asynchronous to the system clock. Each passes through a two-flop synchroniser, and clock and strobe edges are detected in the system clock domain. The top bit of a serial word decides its meaning. When it is clear, the low seven bits become the new attenuation target. When it is set, the attenuation target is kept and the two lowest bits update the emphasis and speed flags.

Top module: `dac_ctrl_port`

## Requirements
- R1: After reset the attenuation target is 0x7F, emphasis is off (0), speed is standard (0) and soft mute is off (0).
- R2: With `mode_sel` low, each rising edge of `line_a` shifts the level of `line_c` into an 8-bit word, most significant bit first.
- R3: With `mode_sel` low, a rising edge of `line_b` on a word whose bit 7 is 0 loads bits 6..0 into `atten_target`. The values 0x00 and 0x7F are both accepted.
- R4: A latched word with bit 7 equal to 1 leaves `atten_target` unchanged. Its bit 0 sets `emph_on` and its bit 1 sets `dbl_speed`.
- R5: With `mode_sel` low, `soft_mute` is 0.
- R6: With `mode_sel` high, `emph_on` follows `line_a`, `dbl_speed` follows `line_b` and `soft_mute` follows `line_c`. A high level means emphasis on, double speed and muted.
- R7: With `mode_sel` high, edges on the lines neither shift nor latch. `atten_target` and the serially set flags survive, and the serial flags reappear when `mode_sel` returns low.
- R8: A level change on a line in parallel mode first appears at the outputs on the third rising clock edge after it is applied.
- R9: When more than eight bits are shifted before a latch, only the last eight count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | 0 = serial word port, 1 = static levels |
| line_a | input | 1 | Shift clock (serial) / emphasis level (parallel) |
| line_b | input | 1 | Latch strobe (serial) / speed level (parallel) |
| line_c | input | 1 | Serial data (serial) / soft mute level (parallel) |
| atten_target | output | 7 | Attenuation target, 0x7F = no attenuation |
| emph_on | output | 1 | De-emphasis enable |
| dbl_speed | output | 1 | Double-speed select |
| soft_mute | output | 1 | Soft mute request |

## Verification
The bench sends attenuation words at both ends of the range, 0x00 and 0x7F. A design that mishandled the range would either reject zero or clip full scale. It sends flag words with bit 7 set and expects the attenuation to stay put; a design that ignored the flag bit would overwrite the attenuation with the flag bits. It shifts ten bits before one latch, which catches a counter that keeps the first eight bits instead of the last eight. It also runs a whole shift-and-latch sequence while in parallel mode and then returns to serial mode, which exposes a port that keeps decoding edges when it should not, or that loses the serial flags. Finally, the bench times a parallel level change edge by edge, so a missing or extra synchroniser stage shows up as an early or late output.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  localparam int WORD_W = 8;
  localparam int ATT_W  = 7;
  localparam int NLINES = 3;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ATT_W-1:0]  att_t;

  localparam att_t ATT_RESET = '1;

  // bit 7 clear: the word carries an attenuation target
  function automatic logic is_att_word(input word_t w);
    return !w[WORD_W-1];
  endfunction

  function automatic att_t att_field(input word_t w);
    return w[ATT_W-1:0];
  endfunction

  function automatic logic flag_emph(input word_t w);
    return w[0];
  endfunction

  function automatic logic flag_speed(input word_t w);
    return w[1];
  endfunction
endpackage

// File: rtl/dac_ctrl_sync.sv
module dac_ctrl_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dac_ctrl_edge.sv
module dac_ctrl_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/dac_ctrl_word.sv
module dac_ctrl_word
  import dac_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ser_en,
  input  logic  clk_rise,
  input  logic  strobe_rise,
  input  logic  din,
  output logic  shift_fire,
  output logic  latch_fire,
  output word_t word_q,
  output att_t  att_q,
  output logic  emph_q,
  output logic  spd_q
);
  assign shift_fire = ser_en && clk_rise;
  assign latch_fire = ser_en && strobe_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          word_q <= '0;
    else if (shift_fire) word_q <= {word_q[WORD_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att_q  <= ATT_RESET;
      emph_q <= 1'b0;
      spd_q  <= 1'b0;
    end else if (latch_fire) begin
      if (is_att_word(word_q)) begin
        att_q <= att_field(word_q);
      end else begin
        emph_q <= flag_emph(word_q);
        spd_q  <= flag_speed(word_q);
      end
    end
  end
endmodule

// File: rtl/dac_ctrl_outsel.sv
module dac_ctrl_outsel
  import dac_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_mode,
  input  logic [NLINES-1:0] lvl,
  input  logic              emph_ser,
  input  logic              spd_ser,
  output logic              emph_on,
  output logic              dbl_speed,
  output logic              soft_mute
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emph_on   <= 1'b0;
      dbl_speed <= 1'b0;
      soft_mute <= 1'b0;
    end else if (par_mode) begin
      emph_on   <= lvl[0];
      dbl_speed <= lvl[1];
      soft_mute <= lvl[2];
    end else begin
      emph_on   <= emph_ser;
      dbl_speed <= spd_ser;
      soft_mute <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_ctrl_port.sv
module dac_ctrl_port
  import dac_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic             line_a,
  input  logic             line_b,
  input  logic             line_c,
  output logic [ATT_W-1:0] atten_target,
  output logic             emph_on,
  output logic             dbl_speed,
  output logic             soft_mute
);
  localparam int SW = NLINES + 1;

  logic [SW-1:0]     sync_q;
  logic [NLINES-1:0] lvl_s;
  logic              par_mode;
  logic [1:0]        rise;
  logic              shift_fire;
  logic              latch_fire;
  word_t             word_q;
  att_t              att_q;
  logic              emph_ser;
  logic              spd_ser;

  dac_ctrl_sync #(.W(SW), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({mode_sel, line_c, line_b, line_a}),
    .q(sync_q)
  );

  assign lvl_s    = sync_q[NLINES-1:0];
  assign par_mode = sync_q[NLINES];

  dac_ctrl_edge #(.W(2)) edge_i (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_s[1:0]), .rise(rise)
  );

  dac_ctrl_word word_i (
    .clk(clk), .rst_n(rst_n), .ser_en(!par_mode),
    .clk_rise(rise[0]), .strobe_rise(rise[1]), .din(lvl_s[2]),
    .shift_fire(shift_fire), .latch_fire(latch_fire),
    .word_q(word_q), .att_q(att_q), .emph_q(emph_ser), .spd_q(spd_ser)
  );

  dac_ctrl_outsel outsel_i (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .lvl(lvl_s),
    .emph_ser(emph_ser), .spd_ser(spd_ser),
    .emph_on(emph_on), .dbl_speed(dbl_speed), .soft_mute(soft_mute)
  );

  assign atten_target = att_q;
endmodule

// File: rtl/dac_ctrl_port_chk.sv
module dac_ctrl_port_chk
  import dac_ctrl_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       par_mode,
  input logic       shift_fire,
  input logic       latch_fire,
  input word_t      word_q,
  input att_t       atten_target,
  input logic       soft_mute,
  input logic       emph_on,
  input logic       dbl_speed,
  input logic [2:0] lvl
);
  // R3: attenuation moves only after a latch of a word with bit 7 clear
  assert_att_only_on_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(atten_target) |-> ($past(latch_fire) && !$past(word_q[WORD_W-1])));

  // R4: a flag word keeps the attenuation target
  assert_flag_word_keeps_att_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_fire && word_q[WORD_W-1]) |=> $stable(atten_target));

  // R5: no soft mute in serial mode
  assert_no_mute_serial_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !par_mode |=> !soft_mute);

  // R6: parallel mode mirrors the synchronised levels
  assert_par_levels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |=> (emph_on == $past(lvl[0]) && dbl_speed == $past(lvl[1])
                  && soft_mute == $past(lvl[2])));

  // R7: in parallel mode the word register and attenuation stay put
  assert_par_no_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |=> ($stable(word_q) && $stable(atten_target)));

  // R2: the word register moves only on a shift event
  assert_word_moves_on_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_fire |=> $stable(word_q));
endmodule

bind dac_ctrl_port dac_ctrl_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .par_mode(par_mode),
  .shift_fire(shift_fire), .latch_fire(latch_fire), .word_q(word_q),
  .atten_target(atten_target), .soft_mute(soft_mute),
  .emph_on(emph_on), .dbl_speed(dbl_speed), .lvl(lvl_s)
);

// File: tb/dac_ctrl_port_tb_top.sv
module dac_ctrl_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 50000;

  typedef struct {
    logic [6:0] att;
    logic       e;
    logic       s;
    logic       m;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0, line_a = 1'b0, line_b = 1'b0, line_c = 1'b0;
  logic [6:0] atten_target;
  logic emph_on, dbl_speed, soft_mute;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_ctrl_port dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .line_a(line_a), .line_b(line_b), .line_c(line_c),
    .atten_target(atten_target), .emph_on(emph_on),
    .dbl_speed(dbl_speed), .soft_mute(soft_mute)
  );

  task automatic compare(input exp_t x);
    n_cmp++;
    if (atten_target !== x.att || emph_on !== x.e || dbl_speed !== x.s || soft_mute !== x.m) begin
      n_bad++;
      $display("FAIL %s: got att=%h e=%b s=%b m=%b, expected att=%h e=%b s=%b m=%b",
               x.tag, atten_target, emph_on, dbl_speed, soft_mute, x.att, x.e, x.s, x.m);
    end
  endtask

  task automatic expect_now(input logic [6:0] a, input logic e, input logic s,
                            input logic m, input string tag);
    exp_t x;
    x.att = a; x.e = e; x.s = s; x.m = m; x.tag = tag;
    compare(x);
  endtask

  task automatic push(input logic [6:0] a, input logic e, input logic s,
                      input logic m, input string tag);
    exp_t x;
    x.att = a; x.e = e; x.s = s; x.m = m; x.tag = tag;
    sb_q.push_back(x);
    wait (sb_q.size() == 0);
  endtask

  task automatic shift_bits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      line_c = bits[i];
      repeat (3) @(negedge clk);
      line_a = 1'b1;
      repeat (4) @(negedge clk);
      line_a = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic strobe();
    line_b = 1'b1;
    repeat (4) @(negedge clk);
    line_b = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_word(input logic [7:0] w);
    shift_bits({8'h00, w}, 8);
    strobe();
    line_c = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops expected items once outputs have settled
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      repeat (5) @(negedge clk);
      compare(sb_q[0]);
      void'(sb_q.pop_front());
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got no completion, expected finish within %0d cycles", WATCHDOG_CYCLES);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_now(7'h7F, 0, 0, 0, "R1 reset state");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_now(7'h7F, 0, 0, 0, "R1 after reset release");

    send_word(8'h40);
    push(7'h40, 0, 0, 0, "R2 R3 attenuation word 0x40");
    send_word(8'h00);
    push(7'h00, 0, 0, 0, "R3 attenuation word 0x00");
    send_word(8'h81);
    push(7'h00, 1, 0, 0, "R4 flag word 0x81");
    send_word(8'h82);
    push(7'h00, 0, 1, 0, "R4 flag word 0x82");
    send_word(8'h83);
    push(7'h00, 1, 1, 0, "R4 R5 flag word 0x83, no mute");

    shift_bits(16'b11_0010_0101, 10);
    strobe();
    line_c = 1'b0;
    push(7'h25, 1, 1, 0, "R9 ten bits, last eight 0x25");

    mode_sel = 1'b1;
    line_a = 1'b1; line_b = 1'b0; line_c = 1'b1;
    push(7'h25, 1, 0, 1, "R6 levels a=1 b=0 c=1");
    line_a = 1'b0; line_b = 1'b1; line_c = 1'b0;
    push(7'h25, 0, 1, 0, "R6 levels a=0 b=1 c=0");

    line_b = 1'b0;
    send_word(8'h11);
    line_a = 1'b0; line_b = 1'b0; line_c = 1'b0;
    push(7'h25, 0, 0, 0, "R7 word ignored in parallel mode");

    // R8: exact latency of a parallel level change
    @(negedge clk);
    line_c = 1'b1;
    repeat (2) @(negedge clk);
    expect_now(7'h25, 0, 0, 0, "R8 mute not yet after two edges");
    @(negedge clk);
    expect_now(7'h25, 0, 0, 1, "R8 mute on third edge");
    line_c = 1'b0;
    repeat (4) @(negedge clk);

    mode_sel = 1'b0;
    push(7'h25, 1, 1, 0, "R7 serial flags restored");

    send_word(8'h7F);
    push(7'h7F, 1, 1, 0, "R3 attenuation word 0x7F");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule